// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block holds the 16-bit status word of an I2C controller that can act as bus master or as slave. The bit-serial protocol engine beside it reports what happens on the bus as single-cycle event strobes: an acknowledge slot has ended, a master transmission has begun, a collision was seen, an address matched (7-bit, second byte of 10-bit, or general call), a Stop was detected, a byte was shifted in, or a transmission finished. The CPU side supplies a transmit-buffer write strobe, a receive-buffer read strobe and a software clear. Each flag follows its own rule for when hardware sets it and when it is cleared. The packed word is presented every cycle for reading.

Some flags are cleared by hardware events, some by Stop, and some only by software. The three error flags (bus collision, write collision, receive overflow) are sticky. Software clears them with a write-0-to-clear mask. Two buffer-occupancy flags are tracked from load and read strobes. They decide whether a new received byte overflows and whether a CPU write to the transmit buffer collides and is dropped. All pins are plain control and status levels or strobes. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `i2c_stat_flags`

## Requirements
- R1: After reset every bit of `stat_word` is 0.
- R2: Bit 15 (ack result) takes the value of `ack_nack` in the cycle after `ev_ack_done`. It reads 1 for a NACK and 0 for an ACK, and it holds in all other cycles.
- R3: Bit 14 (master transmit in progress) sets after `ev_mtx_start` and clears after `ev_ack_done`. If both strobes come in the same cycle, the set wins.
- R4: Bit 10 (bus collision) sets after `ev_collision`. No hardware event clears it, Stop included; only the software clear of R12 does.
- R5: Bit 9 (general call) sets after `ev_gcall_match` and clears after `ev_stop`. If both come in the same cycle, the set wins.
- R6: Bit 8 (10-bit address matched) sets after `ev_addr10_match` and clears after `ev_stop`. If both come in the same cycle, the set wins.
- R7: A `cpu_tx_wr` that arrives while bit 0 is 1 or `eng_busy` is 1 sets bit 7 (write collision). That write is discarded and does not set bit 0. Bit 7 is cleared only by software.
- R8: An `ev_rx_byte` that arrives while bit 1 is 1 and `cpu_rx_rd` is 0 sets bit 6 (receive overflow). Bit 1 stays 1. Bit 6 is cleared only by software.
- R9: Bit 5 (last byte was data) clears after `ev_addr_match`, `ev_addr10_match` or `ev_gcall_match`. It sets after `ev_tx_done` or `ev_rx_data`. When both kinds of event come in the same cycle, the clear wins.
- R10: Bit 1 (receive buffer full) sets after `ev_rx_byte` and clears after `cpu_rx_rd` when no byte arrives in that cycle. Bit 0 (transmit buffer full) sets after an accepted `cpu_tx_wr` and clears after `eng_tx_load`.
- R11: Bits 13 to 11 and bits 4 to 2 always read 0.
- R12: With `sw_clr_en` high, each of bits 10, 7 and 6 whose `sw_clr_mask` bit is 0 clears. Mask bits that are 1 leave their flag alone. All other status bits ignore the clear. A hardware set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_ack_done | input | 1 | Acknowledge slot ended |
| ack_nack | input | 1 | Value sampled in that slot, 1 = NACK |
| ev_mtx_start | input | 1 | Master transmission begins |
| ev_collision | input | 1 | Bus collision in a master operation |
| ev_addr_match | input | 1 | 7-bit device address matched |
| ev_addr10_match | input | 1 | Second byte of 10-bit address matched |
| ev_gcall_match | input | 1 | General call address received |
| ev_stop | input | 1 | Stop condition detected |
| ev_rx_byte | input | 1 | Shifted byte ready for the receive buffer |
| ev_rx_data | input | 1 | Slave data byte received |
| ev_tx_done | input | 1 | Transmission completed |
| eng_busy | input | 1 | Protocol engine busy |
| eng_tx_load | input | 1 | Engine took the transmit buffer |
| cpu_tx_wr | input | 1 | CPU write to the transmit buffer |
| cpu_rx_rd | input | 1 | CPU read of the receive buffer |
| sw_clr_en | input | 1 | Software clear strobe |
| sw_clr_mask | input | 16 | Write-0-to-clear mask |
| stat_word | output | 16 | Packed status word |

## Verification
The hardest cases to reach are the same-cycle collisions between a hardware set and a clear. Examples are a collision strobe together with a software clear, a general call together with Stop, and a byte arrival together with a buffer read. In each case one input cycle has to carry both events. The directed tasks drive both strobes on the same falling edge and check the winner one cycle later. Write collision is reached in two ways: first by filling the transmit buffer and writing again, then with the buffer empty but the engine busy. In the second case the dropped write shows at the port because bit 0 stays 0.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int STAT_W = 16;
  localparam int B_ACK  = 15;
  localparam int B_TRN  = 14;
  localparam int B_BCL  = 10;
  localparam int B_GC   = 9;
  localparam int B_A10  = 8;
  localparam int B_WCOL = 7;
  localparam int B_OVF  = 6;
  localparam int B_DA   = 5;
  localparam int B_RBF  = 1;
  localparam int B_TBF  = 0;
  localparam logic [STAT_W-1:0] SW_CLR_BITS =
    STAT_W'((1 << B_BCL) | (1 << B_WCOL) | (1 << B_OVF));
endpackage

// File: rtl/stat_flag.sv
module stat_flag #(
  parameter bit CLR_WINS = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  generate
    if (CLR_WINS) begin : g_clr_first
      always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (clr_i) q <= 1'b0;
        else if (set_i) q <= 1'b1;
      end
    end else begin : g_set_first
      always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/stat_buf_track.sv
module stat_buf_track (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_byte,
  input  logic rx_rd,
  input  logic tx_wr,
  input  logic tx_load,
  input  logic eng_busy,
  output logic rbf,
  output logic tbf,
  output logic ovf_hit,
  output logic wcol_hit
);
  assign ovf_hit  = rx_byte && rbf && !rx_rd;
  assign wcol_hit = tx_wr && (tbf || eng_busy);

  always_ff @(posedge clk) begin
    if (!rst_n)       rbf <= 1'b0;
    else if (rx_byte) rbf <= 1'b1;
    else if (rx_rd)   rbf <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  tbf <= 1'b0;
    else if (tx_wr && !wcol_hit) tbf <= 1'b1;
    else if (tx_load)            tbf <= 1'b0;
  end

  p_ovf_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> rbf);
  p_wcol_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol_hit && !tx_load) |=> (tbf == $past(tbf)));
  p_rd_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !rx_byte) |=> !rbf);
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_ack_done,
  input  logic              ack_nack,
  input  logic              ev_mtx_start,
  input  logic              ev_collision,
  input  logic              ev_addr_match,
  input  logic              ev_addr10_match,
  input  logic              ev_gcall_match,
  input  logic              ev_stop,
  input  logic              ev_rx_byte,
  input  logic              ev_rx_data,
  input  logic              ev_tx_done,
  input  logic              eng_busy,
  input  logic              eng_tx_load,
  input  logic              cpu_tx_wr,
  input  logic              cpu_rx_rd,
  input  logic              sw_clr_en,
  input  logic [STAT_W-1:0] sw_clr_mask,
  output logic [STAT_W-1:0] stat_word
);
  logic [STAT_W-1:0] sw_clr;
  logic f_ack, f_trn, f_bcl, f_gc, f_a10, f_wcol, f_ovf, f_da, f_rbf, f_tbf;
  logic ovf_hit, wcol_hit, any_match;

  // write-0-to-clear, restricted to the sticky error bits
  assign sw_clr    = sw_clr_en ? (~sw_clr_mask & SW_CLR_BITS) : '0;
  assign any_match = ev_addr_match | ev_addr10_match | ev_gcall_match;

  stat_buf_track u_buf (
    .clk(clk), .rst_n(rst_n), .rx_byte(ev_rx_byte), .rx_rd(cpu_rx_rd),
    .tx_wr(cpu_tx_wr), .tx_load(eng_tx_load), .eng_busy(eng_busy),
    .rbf(f_rbf), .tbf(f_tbf), .ovf_hit(ovf_hit), .wcol_hit(wcol_hit)
  );

  stat_flag #(.CLR_WINS(1'b0)) u_ack (.clk(clk), .rst_n(rst_n),
    .set_i(ev_ack_done & ack_nack), .clr_i(ev_ack_done & ~ack_nack), .q(f_ack));
  stat_flag #(.CLR_WINS(1'b0)) u_trn (.clk(clk), .rst_n(rst_n),
    .set_i(ev_mtx_start), .clr_i(ev_ack_done), .q(f_trn));
  stat_flag #(.CLR_WINS(1'b0)) u_bcl (.clk(clk), .rst_n(rst_n),
    .set_i(ev_collision), .clr_i(sw_clr[B_BCL]), .q(f_bcl));
  stat_flag #(.CLR_WINS(1'b0)) u_gc (.clk(clk), .rst_n(rst_n),
    .set_i(ev_gcall_match), .clr_i(ev_stop), .q(f_gc));
  stat_flag #(.CLR_WINS(1'b0)) u_a10 (.clk(clk), .rst_n(rst_n),
    .set_i(ev_addr10_match), .clr_i(ev_stop), .q(f_a10));
  stat_flag #(.CLR_WINS(1'b0)) u_wcol (.clk(clk), .rst_n(rst_n),
    .set_i(wcol_hit), .clr_i(sw_clr[B_WCOL]), .q(f_wcol));
  stat_flag #(.CLR_WINS(1'b0)) u_ovf (.clk(clk), .rst_n(rst_n),
    .set_i(ovf_hit), .clr_i(sw_clr[B_OVF]), .q(f_ovf));
  stat_flag #(.CLR_WINS(1'b1)) u_da (.clk(clk), .rst_n(rst_n),
    .set_i(ev_tx_done | ev_rx_data), .clr_i(any_match), .q(f_da));

  always_comb begin
    stat_word         = '0;
    stat_word[B_ACK]  = f_ack;
    stat_word[B_TRN]  = f_trn;
    stat_word[B_BCL]  = f_bcl;
    stat_word[B_GC]   = f_gc;
    stat_word[B_A10]  = f_a10;
    stat_word[B_WCOL] = f_wcol;
    stat_word[B_OVF]  = f_ovf;
    stat_word[B_DA]   = f_da;
    stat_word[B_RBF]  = f_rbf;
    stat_word[B_TBF]  = f_tbf;
  end

  p_ack_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_done |=> (stat_word[B_ACK] == $past(ack_nack)));
  p_trn_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mtx_start |=> stat_word[B_TRN]);
  p_bcl_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[B_BCL] && !(sw_clr_en && !sw_clr_mask[B_BCL])) |=> stat_word[B_BCL]);
  p_gc_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !ev_gcall_match) |=> !stat_word[B_GC]);
  p_a10_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !ev_addr10_match) |=> !stat_word[B_A10]);
  p_da_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any_match |=> !stat_word[B_DA]);
  p_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[13:11] == 3'b000) && (stat_word[4:2] == 3'b000));
  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_collision && sw_clr_en) |=> stat_word[B_BCL]);
endmodule

// File: tb/tb_i2c_stat_flags.sv
module tb_i2c_stat_flags;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_ack_done, ack_nack, ev_mtx_start, ev_collision, ev_addr_match;
  logic ev_addr10_match, ev_gcall_match, ev_stop, ev_rx_byte, ev_rx_data;
  logic ev_tx_done, eng_busy, eng_tx_load, cpu_tx_wr, cpu_rx_rd, sw_clr_en;
  logic [15:0] sw_clr_mask, stat_word;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_stat_flags dut (.*);

  task automatic idle();
    {ev_ack_done, ack_nack, ev_mtx_start, ev_collision, ev_addr_match,
     ev_addr10_match, ev_gcall_match, ev_stop, ev_rx_byte, ev_rx_data,
     ev_tx_done, eng_busy, eng_tx_load, cpu_tx_wr, cpu_rx_rd, sw_clr_en} = '0;
    sw_clr_mask = 16'hFFFF;
  endtask

  // inputs already driven after a falling edge; pass one rising edge, clear, sample
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic chk(string req, int idx, logic exp);
    total++;
    if (stat_word[idx] !== exp) begin
      bad++;
      $display("FAIL %s bit%0d actual=%b expected=%b", req, idx, stat_word[idx], exp);
    end
  endtask

  task automatic chk_word(string req, logic [15:0] msk, logic [15:0] exp);
    total++;
    if ((stat_word & msk) !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, stat_word & msk, exp);
    end
  endtask

  task automatic t_reset();
    chk_word("R1", 16'hFFFF, 16'h0000);
  endtask

  task automatic t_ack();
    ev_ack_done = 1; ack_nack = 1; step(); chk("R2", 15, 1);
    step(); chk("R2", 15, 1);
    ev_ack_done = 1; ack_nack = 0; step(); chk("R2", 15, 0);
  endtask

  task automatic t_trn();
    ev_mtx_start = 1; step(); chk("R3", 14, 1);
    ev_ack_done = 1; step(); chk("R3", 14, 0);
    ev_mtx_start = 1; ev_ack_done = 1; step(); chk("R3", 14, 1);
    ev_ack_done = 1; step(); chk("R3", 14, 0);
  endtask

  task automatic t_bcl();
    ev_collision = 1; step(); chk("R4", 10, 1);
    ev_stop = 1; step(); chk("R4", 10, 1);
    sw_clr_en = 1; step(); chk("R12", 10, 1);
    sw_clr_en = 1; sw_clr_mask = 16'hFBFF; step(); chk("R12", 10, 0);
    ev_collision = 1; sw_clr_en = 1; sw_clr_mask = 16'h0000; step(); chk("R12", 10, 1);
    sw_clr_en = 1; sw_clr_mask = 16'hFBFF; step(); chk("R4", 10, 0);
  endtask

  task automatic t_gc();
    ev_rx_data = 1; step(); chk("R9", 5, 1);
    ev_gcall_match = 1; step(); chk("R5", 9, 1); chk("R9", 5, 0);
    ev_stop = 1; step(); chk("R5", 9, 0);
    ev_gcall_match = 1; ev_stop = 1; step(); chk("R5", 9, 1);
    ev_stop = 1; step(); chk("R5", 9, 0);
  endtask

  task automatic t_a10();
    ev_addr10_match = 1; step(); chk("R6", 8, 1);
    step(); chk("R6", 8, 1);
    ev_stop = 1; step(); chk("R6", 8, 0);
    ev_addr10_match = 1; ev_stop = 1; step(); chk("R6", 8, 1);
    ev_stop = 1; step(); chk("R6", 8, 0);
  endtask

  task automatic t_da();
    ev_tx_done = 1; step(); chk("R9", 5, 1);
    ev_addr_match = 1; step(); chk("R9", 5, 0);
    ev_rx_data = 1; step(); chk("R9", 5, 1);
    ev_tx_done = 1; ev_addr_match = 1; step(); chk("R9", 5, 0);
  endtask

  task automatic t_tx();
    cpu_tx_wr = 1; step(); chk("R10", 0, 1); chk("R7", 7, 0);
    cpu_tx_wr = 1; step(); chk("R7", 7, 1); chk("R10", 0, 1);
    eng_tx_load = 1; step(); chk("R10", 0, 0);
    eng_busy = 1; cpu_tx_wr = 1; step(); chk("R7", 0, 0); chk("R7", 7, 1);
    ev_stop = 1; step(); chk("R7", 7, 1);
    sw_clr_en = 1; sw_clr_mask = 16'hFF7F; step(); chk("R7", 7, 0);
  endtask

  task automatic t_rx();
    ev_rx_byte = 1; step(); chk("R10", 1, 1); chk("R8", 6, 0);
    ev_rx_byte = 1; step(); chk("R8", 6, 1); chk("R8", 1, 1);
    cpu_rx_rd = 1; step(); chk("R10", 1, 0);
    sw_clr_en = 1; sw_clr_mask = 16'hFFBF; step(); chk("R8", 6, 0);
    ev_rx_byte = 1; step();
    ev_rx_byte = 1; cpu_rx_rd = 1; step(); chk("R8", 6, 0); chk("R10", 1, 1);
    cpu_rx_rd = 1; step(); chk("R10", 1, 0);
  endtask

  task automatic t_swclr_scope();
    ev_ack_done = 1; ack_nack = 1; ev_gcall_match = 1; ev_mtx_start = 1;
    ev_rx_byte = 1; cpu_tx_wr = 1; step();
    ev_tx_done = 1; step();
    sw_clr_en = 1; sw_clr_mask = 16'h0000; step();
    chk_word("R12", 16'hC323, 16'hC223);
    chk_word("R11", 16'h381C, 16'h0000);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ack();
    t_trn();
    t_bcl();
    t_gc();
    t_a10();
    t_da();
    t_tx();
    t_rx();
    t_swclr_scope();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule